// File: doc/BRIEF.md
# Comparator-Free Programmable PWM Generator

This block produces a single pulse-width-modulated line without any magnitude comparator. A frame down-counter sets the length of each PWM frame. A second down-counter, reloaded at every frame boundary, times how long the output stays high. Both counters report their terminal count through the borrow out of their decrement. The frame terminal count sets a set-reset output flop, and the duty terminal count clears it.

Software or a neighbouring block writes a period and a duty value through a one-cycle write strobe. The values go into holding registers. The counters pick them up only at the next frame boundary, so every frame is built from one consistent pair. A frame-boundary pulse is also provided so that other logic can align to the PWM frame.

Top module: `pwm_twocnt`

## Requirements
- R1: Synchronous reset clears both counters, both holding registers and the output. In every cycle of reset, `pwm_out` is 0 and `frame_start` is 0. In the first cycle after reset is released, `frame_start` is 1.
- R2: A frame lasts P cycles for a held period value P of 1 or more, and 1 cycle for P = 0. `frame_start` is 1 exactly once per frame, in the last cycle of that frame. The counter that sets this length runs down by one per cycle and reloads itself at its terminal count.
- R3: For a held duty D with 0 < D < P, `pwm_out` is 1 for the first D cycles of each frame and 0 for the rest. The first cycle of a frame is the one that follows a `frame_start` cycle.
- R4: A held duty of 0 keeps `pwm_out` at 0 for the whole frame. When the frame boundary sets the output and the duty value is zero, the zero duty wins.
- R5: A held duty D with D >= max(P,1) keeps `pwm_out` at 1 through the whole frame and across frame boundaries, with no low cycle.
- R6: A write during a frame does not change that frame. The frame that follows the next `frame_start` cycle uses the new values. A write in a `frame_start` cycle is applied one frame later.
- R7: While `wr_en` is 0, `period_in` and `duty_in` have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the period and duty holding registers |
| period_in | input | CW | Frame length in cycles (0 is treated as 1) |
| duty_in | input | CW | High time in cycles at the start of each frame |
| pwm_out | output | 1 | PWM output |
| frame_start | output | 1 | High in the last cycle of each frame |

## Verification
The assertions assume that reset is asserted at time zero and held for at least one clock edge. They also assume that `wr_en` is the only path by which the holding registers change. The bench drives all inputs on the falling clock edge and raises the write strobe for exactly one cycle per update. It changes the data buses freely while the strobe is low. Duty values are kept on both sides of the period, and zero, one and the counter maximum are included. This exercises the boundary-versus-terminal-count priority without relying on unspecified behaviour.

// File: rtl/pwm_twocnt_pkg.sv
package pwm_twocnt_pkg;

    typedef enum logic [1:0] {
        SR_HOLD = 2'd0,
        SR_SET  = 2'd1,
        SR_CLR  = 2'd2
    } sr_act_e;

    // Boundary decision has priority over a pending duty terminal count.
    function automatic sr_act_e sr_pick(input logic boundary,
                                        input logic duty_nonzero,
                                        input logic duty_done);
        if (boundary)
            return duty_nonzero ? SR_SET : SR_CLR;
        else if (duty_done)
            return SR_CLR;
        else
            return SR_HOLD;
    endfunction

    function automatic logic sr_next(input sr_act_e act, input logic q);
        case (act)
            SR_SET:  return 1'b1;
            SR_CLR:  return 1'b0;
            default: return q;
        endcase
    endfunction

endpackage

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] reload_val,
    output logic [CW-1:0] cnt,
    output logic          tc
);
    logic [CW-1:0] dec;

    // Terminal count is the borrow out of the decrement.
    assign {tc, dec} = {1'b0, cnt} - {{CW{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tc)
            cnt <= reload_val;
        else
            cnt <= dec;
    end
endmodule

// File: rtl/pwm_duty_ctr.sv
module pwm_duty_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          run,
    output logic          tc
);
    logic [CW-1:0] dec;
    logic          borrow;

    assign {borrow, dec} = {1'b0, cnt} - {{CW{1'b0}}, 1'b1};
    assign tc = run & borrow;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= load_val - {{(CW-1){1'b0}}, 1'b1};
            run <= (load_val != '0);
        end else if (run) begin
            if (borrow)
                run <= 1'b0;
            else
                cnt <= dec;
        end
    end
endmodule

// File: rtl/pwm_sr_out.sv
module pwm_sr_out
    import pwm_twocnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic boundary,
    input  logic duty_nonzero,
    input  logic duty_done,
    output logic q
);
    sr_act_e act;

    always_comb act = sr_pick(boundary, duty_nonzero, duty_done);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= sr_next(act, q);
    end
endmodule

// File: rtl/pwm_twocnt.sv
module pwm_twocnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] period_in,
    input  logic [CW-1:0] duty_in,
    output logic          pwm_out,
    output logic          frame_start
);
    logic [CW-1:0] per_q;
    logic [CW-1:0] duty_q;
    logic [CW-1:0] frame_load;
    logic [CW-1:0] frame_cnt;
    logic          frame_tc;
    logic [CW-1:0] duty_cnt;
    logic          duty_run;
    logic          duty_tc;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q  <= '0;
            duty_q <= '0;
        end else if (wr_en) begin
            per_q  <= period_in;
            duty_q <= duty_in;
        end
    end

    assign frame_load = (per_q == '0) ? '0 : per_q - {{(CW-1){1'b0}}, 1'b1};

    pwm_frame_ctr #(.CW(CW)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .reload_val (frame_load),
        .cnt        (frame_cnt),
        .tc         (frame_tc)
    );

    pwm_duty_ctr #(.CW(CW)) u_duty (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_tc),
        .load_val (duty_q),
        .cnt      (duty_cnt),
        .run      (duty_run),
        .tc       (duty_tc)
    );

    pwm_sr_out u_out (
        .clk          (clk),
        .rst          (rst),
        .boundary     (frame_tc),
        .duty_nonzero (duty_q != '0),
        .duty_done    (duty_tc),
        .q            (pwm_out)
    );

    assign frame_start = frame_tc & ~rst;
endmodule

// File: rtl/pwm_twocnt_chk.sv
module pwm_twocnt_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          pwm_out,
    input logic          frame_start,
    input logic [CW-1:0] per_q,
    input logic [CW-1:0] duty_q,
    input logic [CW-1:0] frame_cnt,
    input logic [CW-1:0] duty_cnt,
    input logic          duty_run
);
    logic [CW-1:0] exp_reload;
    assign exp_reload = (per_q == '0) ? '0 : per_q - 1'b1;

    a_r1_first_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (frame_start && !pwm_out));

    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (frame_cnt == $past(exp_reload)));

    a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> (frame_cnt == $past(frame_cnt) - 1'b1));

    a_r3_boundary_set: assert property (@(posedge clk) disable iff (rst)
        (frame_start && duty_q != '0) |=> pwm_out);

    a_r3_duty_clear: assert property (@(posedge clk) disable iff (rst)
        (duty_run && duty_cnt == '0 && !frame_start) |=> !pwm_out);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !duty_run) |=> $stable(pwm_out));

    a_r4_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (frame_start && duty_q == '0) |=> !pwm_out);

    a_r7_hold_regs: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(per_q) && $stable(duty_q)));
endmodule

bind pwm_twocnt pwm_twocnt_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .pwm_out     (pwm_out),
    .frame_start (frame_start),
    .per_q       (per_q),
    .duty_q      (duty_q),
    .frame_cnt   (frame_cnt),
    .duty_cnt    (duty_cnt),
    .duty_run    (duty_run)
);

// File: tb/pwm_twocnt_test.sv
module pwm_twocnt_test;
    localparam int CW = 8;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [CW-1:0] period_in = '0;
    logic [CW-1:0] duty_in = '0;
    logic          pwm_out;
    logic          frame_start;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_twocnt #(.CW(CW)) uut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .period_in   (period_in),
        .duty_in     (duty_in),
        .pwm_out     (pwm_out),
        .frame_start (frame_start)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input int p, input int d);
        @(negedge clk);
        wr_en     = 1'b1;
        period_in = CW'(p);
        duty_in   = CW'(d);
        @(negedge clk);
        wr_en     = 1'b0;
        // R7: junk on the buses while the strobe is low
        period_in = 8'hA5;
        duty_in   = 8'h5A;
    endtask

    task automatic sync_frame();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!frame_start && guard < 400);
    endtask

    // Caller is at the negedge of a frame_start cycle.
    task automatic check_frame(input string req, input int p, input int d);
        int len = (p < 1) ? 1 : p;
        int hi  = (d > len) ? len : d;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            check(req, pwm_out, (k <= hi) ? 1'b1 : 1'b0);
            check({req, "/frame_start"}, frame_start, (k == len) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic t_reset();
        repeat (3) begin
            @(negedge clk);
            check("R1 pwm in reset", pwm_out, 1'b0);
            check("R1 frame_start in reset", frame_start, 1'b0);
        end
        rst = 1'b0;
        #1;
        check("R1 first frame_start", frame_start, 1'b1);
        check("R1 pwm after release", pwm_out, 1'b0);
        // R2: P=0 gives one-cycle frames, R4: duty 0 keeps low
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 zero period frame", frame_start, 1'b1);
            check("R4 reset duty zero", pwm_out, 1'b0);
        end
    endtask

    task automatic t_basic();
        write_cfg(10, 3);
        sync_frame();
        check_frame("R3 P10 D3", 10, 3);
        check_frame("R3 P10 D3 repeat (R7 junk)", 10, 3);
        write_cfg(7, 1);
        sync_frame();
        check_frame("R3 P7 D1", 7, 1);
        write_cfg(5, 4);
        sync_frame();
        check_frame("R3 P5 D4", 5, 4);
    endtask

    task automatic t_extremes();
        write_cfg(6, 0);
        sync_frame();
        check_frame("R4 D0", 6, 0);
        check_frame("R4 D0 repeat", 6, 0);
        write_cfg(7, 7);
        sync_frame();
        check_frame("R5 D==P", 7, 7);
        check_frame("R5 D==P repeat", 7, 7);
        write_cfg(4, 255);
        sync_frame();
        check_frame("R5 D>P", 4, 255);
        write_cfg(1, 1);
        sync_frame();
        check_frame("R2 P1 D1", 1, 1);
        check_frame("R5 P1 D1 repeat", 1, 1);
        write_cfg(0, 3);
        sync_frame();
        check_frame("R5 P0 D3", 0, 3);
        check_frame("R2 P0 repeat", 0, 3);
    endtask

    task automatic t_midframe();
        write_cfg(10, 3);
        sync_frame();
        check_frame("R6 settle", 10, 3);
        // R6: write in cycle 4 of the current frame; that frame stays old
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            check("R6 old frame kept", pwm_out, (k <= 3) ? 1'b1 : 1'b0);
            check("R6 old frame length", frame_start, (k == 10) ? 1'b1 : 1'b0);
            if (k == 4) begin
                wr_en = 1'b1; period_in = 8'd6; duty_in = 8'd5;
            end else begin
                wr_en = 1'b0; period_in = 8'hFF; duty_in = 8'h00;
            end
        end
        check_frame("R6 new frame", 6, 5);
        // R6: write during the frame_start cycle applies one frame later
        wr_en = 1'b1; period_in = 8'd4; duty_in = 8'd2;
        check_frame("R6 boundary write old", 6, 5);
        check_frame("R6 boundary write new", 4, 2);
    endtask

    task automatic t_midrun_reset();
        write_cfg(8, 8);
        sync_frame();
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset pwm", pwm_out, 1'b0);
        check("R1 mid-run reset frame_start", frame_start, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 restart frame_start", frame_start, 1'b1);
        @(negedge clk);
        check("R1 regs cleared pwm low", pwm_out, 1'b0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_extremes();
        t_midframe();
        t_midrun_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule